// File: doc/BRIEF.md
# Serial Channel Mode Router

This block sits between the byte-level side of a serial port and its software-visible data register. It decides where each byte goes. Bytes come from the receiver, from a data-register write, or from a received break. They go to a receive FIFO, a transmit FIFO, or nowhere. The choice depends on a 2-bit channel mode and on the enable and disable bits of a control register.

Four modes are supported:
- **Normal:** received bytes are stored for software, and software writes are transmitted.
- **Automatic echo:** received bytes are stored and are also sent back out.
- **Local loopback:** software writes come straight back into the receive FIFO.
- **Remote loopback:** received bytes are sent back out and software sees nothing.

Bit-level serialisation is not part of this block. The receive stream is offered a ready signal so that a well-behaved source never overflows the FIFO (or FIFOs) that the current mode feeds.

The control register also holds two self-clearing flush bits, one for each FIFO. A single-cycle overrun pulse reports any byte that was dropped because its destination FIFO was full.

Top module: `uart_chan_router`

## Requirements
- R1: The mode input is encoded as 0 normal, 1 automatic echo, 2 local loopback and 3 remote loopback. A received byte (ser_valid high, ser_break low) is pushed into the RX FIFO in modes 0 and 1 only.
- R2: A received byte is pushed into the TX FIFO in modes 1 and 3 only.
- R3: A data-register write is pushed into the TX FIFO in mode 0 and into the RX FIFO in mode 2. In modes 1 and 3 it is dropped and changes neither FIFO.
- R4: Control bit 2 enables RX and bit 3 disables it. The RX path is open only when bit 2 is 1 and bit 3 is 0. While the RX path is closed, pushes to the RX FIFO are dropped and data reads neither pop nor return data. Bits 4 (enable) and 5 (disable) gate pushes to the TX FIFO the same way.
- R5: A push into a full FIFO is dropped. overrun is high for exactly the one cycle after that clock edge.
- R6: A data read pops the oldest RX byte, in arrival order. dr_rdata shows that byte during the read cycle. dr_rdata is zero when the RX FIFO is empty or the RX path is closed.
- R7: Writing control bit 0 empties the RX FIFO, and writing bit 1 empties the TX FIFO. Both bits read back as 0 after the write.
- R8: After reset, ctrl_q is 0x128 and both FIFOs are empty.
- R9: A ser_break pulse pushes a single zero byte into the RX FIFO in any mode, subject to R4. A ser_valid in the same cycle is ignored.
- R10: ser_ready is low exactly when a FIFO that the current mode feeds from the receiver is full. It stays high in local loopback.
- R11: out_valid is high while the TX FIFO holds data. out_data is its oldest byte, which is popped at an edge with out_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_mode | input | 2 | Channel mode (R1) |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control write value |
| ctrl_q | output | 9 | Control register contents |
| ser_valid | input | 1 | Received byte present |
| ser_data | input | DATA_W | Received byte |
| ser_break | input | 1 | Break condition received |
| ser_ready | output | 1 | Receiver may deliver a byte |
| out_valid | output | 1 | Byte available for the transmitter |
| out_data | output | DATA_W | Byte to transmit |
| out_ready | input | 1 | Transmitter takes the byte |
| dr_wr | input | 1 | Data register write |
| dr_wdata | input | DATA_W | Data register write value |
| dr_rd | input | 1 | Data register read (pops RX FIFO) |
| dr_rdata | output | DATA_W | Data register read value |
| overrun | output | 1 | One-cycle pulse for a dropped push |

## Verification
The assertions assume the following about the inputs:
- chan_mode is held steady around each transfer.
- ser_valid, ser_break, dr_wr, dr_rd and out_ready are single-cycle strobes driven away from the clock edge.
- A control write is not issued in the same cycle as a data transfer that it might gate.

The stimulus keeps to these rules. It changes the mode only between transfers, and it lets each control write settle for a cycle before the next byte moves. For this reason, the checks on blocked paths and on discarded writes see FIFO counts that no other stimulus has changed.

// File: rtl/chan_router_pkg.sv
package chan_router_pkg;
   typedef enum logic [1:0] {
      MODE_NORMAL    = 2'd0,
      MODE_ECHO      = 2'd1,
      MODE_LOCAL_LB  = 2'd2,
      MODE_REMOTE_LB = 2'd3
   } chan_mode_e;

   localparam int CTRL_W = 9;
   // bit positions of the control word; reset value depends on them
   localparam int CB_RX_FLUSH = 0;
   localparam int CB_TX_FLUSH = 1;
   localparam int CB_RX_ON    = 2;
   localparam int CB_RX_OFF   = 3;
   localparam int CB_TX_ON    = 4;
   localparam int CB_TX_OFF   = 5;
   localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;
endpackage

// File: rtl/byte_ring.sv
module byte_ring #(
   parameter  int W     = 8,
   parameter  int DEPTH = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_depth_bad
         $error("byte_ring: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_width_bad
         $error("byte_ring: W must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   // pointer wrap: free-running for power-of-two depths, compare otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = mem[rd_ptr];
   assign count   = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= din;
   end

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (full && wr_ptr == $past(wr_ptr)));
endmodule

// File: rtl/route_ctrl.sv
module route_ctrl
   import chan_router_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              rx_flush,
   output logic              tx_flush,
   output logic              rx_on,
   output logic              tx_on
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
      end else if (wr) begin
         ctrl_q              <= wdata;
         ctrl_q[CB_RX_FLUSH] <= 1'b0;
         ctrl_q[CB_TX_FLUSH] <= 1'b0;
      end
   end

   assign rx_flush = wr & wdata[CB_RX_FLUSH];
   assign tx_flush = wr & wdata[CB_TX_FLUSH];
   assign rx_on    = ctrl_q[CB_RX_ON] & ~ctrl_q[CB_RX_OFF];
   assign tx_on    = ctrl_q[CB_TX_ON] & ~ctrl_q[CB_TX_OFF];
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
   import chan_router_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int RX_DEPTH = 16,
   parameter int TX_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        chan_mode,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   input  logic              ser_valid,
   input  logic [DATA_W-1:0] ser_data,
   input  logic              ser_break,
   output logic              ser_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready,
   input  logic              dr_wr,
   input  logic [DATA_W-1:0] dr_wdata,
   input  logic              dr_rd,
   output logic [DATA_W-1:0] dr_rdata,
   output logic              overrun
);
   localparam int RX_CW = $clog2(RX_DEPTH + 1);
   localparam int TX_CW = $clog2(TX_DEPTH + 1);

   chan_mode_e        mode;
   logic              rx_flush, tx_flush, rx_on, tx_on;
   logic              ser_acc, ser_to_rx, ser_to_tx;
   logic              rx_push, tx_push, rx_pop;
   logic [DATA_W-1:0] rx_din, tx_din, rx_dout;
   logic              rx_full, rx_empty, tx_full, tx_empty;
   logic [RX_CW-1:0]  rx_count;
   logic [TX_CW-1:0]  tx_count;

   route_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ctrl_wr),
      .wdata    (ctrl_wdata),
      .ctrl_q   (ctrl_q),
      .rx_flush (rx_flush),
      .tx_flush (tx_flush),
      .rx_on    (rx_on),
      .tx_on    (tx_on)
   );

   assign mode      = chan_mode_e'(chan_mode);
   assign ser_acc   = ser_valid & ~ser_break;
   assign ser_to_rx = (mode == MODE_NORMAL) || (mode == MODE_ECHO);
   assign ser_to_tx = (mode == MODE_ECHO) || (mode == MODE_REMOTE_LB);

   // RX FIFO source: break first, then receiver, then loopback write
   always_comb begin
      rx_din  = dr_wdata;
      rx_push = 1'b0;
      if (ser_break) begin
         rx_din  = '0;
         rx_push = 1'b1;
      end else if (ser_acc && ser_to_rx) begin
         rx_din  = ser_data;
         rx_push = 1'b1;
      end else if (dr_wr && mode == MODE_LOCAL_LB) begin
         rx_push = 1'b1;
      end
      rx_push = rx_push & rx_on;
   end

   // TX FIFO source: sources are exclusive by mode
   always_comb begin
      tx_din  = dr_wdata;
      tx_push = 1'b0;
      if (ser_acc && ser_to_tx) begin
         tx_din  = ser_data;
         tx_push = 1'b1;
      end else if (dr_wr && mode == MODE_NORMAL) begin
         tx_push = 1'b1;
      end
      tx_push = tx_push & tx_on;
   end

   assign rx_pop    = dr_rd & rx_on;
   assign dr_rdata  = (rx_on && !rx_empty) ? rx_dout : '0;
   assign out_valid = ~tx_empty;
   assign ser_ready = ~((ser_to_rx & rx_full) | (ser_to_tx & tx_full));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) overrun <= 1'b0;
      else        overrun <= (rx_push & rx_full & ~rx_flush) |
                             (tx_push & tx_full & ~tx_flush);
   end

   byte_ring #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (rx_flush),
      .push  (rx_push),
      .din   (rx_din),
      .pop   (rx_pop),
      .dout  (rx_dout),
      .full  (rx_full),
      .empty (rx_empty),
      .count (rx_count)
   );

   byte_ring #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (tx_flush),
      .push  (tx_push),
      .din   (tx_din),
      .pop   (out_ready),
      .dout  (out_data),
      .full  (tx_full),
      .empty (tx_empty),
      .count (tx_count)
   );

   assert_rx_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_on && !rx_flush) |=> (rx_count == $past(rx_count)));

   assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && ctrl_wdata[CB_RX_FLUSH]) |=> (!ctrl_q[CB_RX_FLUSH] && rx_count == '0));

   assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_rd && rx_count == '0) |-> (dr_rdata == '0));

   assert_discard_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_wr && (mode == MODE_ECHO || mode == MODE_REMOTE_LB) && !ser_valid &&
       !ser_break && !out_ready && !ctrl_wr) |=> (tx_count == $past(tx_count)));

   assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_acc && ser_to_rx && rx_on && rx_count == RX_CW'(RX_DEPTH) && !ctrl_wr) |=> overrun);
endmodule

// File: tb/uart_chan_router_test.sv
module uart_chan_router_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;

   // {mode[12:11], is_dreg_write[10], data[9:2], lands_in_rx[1], lands_in_tx[0]}
   localparam logic [12:0] VEC [8] = '{
      {2'd0, 1'b0, 8'hA1, 1'b1, 1'b0},
      {2'd0, 1'b1, 8'hB2, 1'b0, 1'b1},
      {2'd1, 1'b0, 8'hC3, 1'b1, 1'b1},
      {2'd1, 1'b1, 8'hD4, 1'b0, 1'b0},
      {2'd2, 1'b0, 8'hE5, 1'b0, 1'b0},
      {2'd2, 1'b1, 8'hF6, 1'b1, 1'b0},
      {2'd3, 1'b0, 8'h17, 1'b0, 1'b1},
      {2'd3, 1'b1, 8'h28, 1'b0, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] chan_mode = 2'd0;
   logic       ctrl_wr = 1'b0;
   logic [8:0] ctrl_wdata = '0;
   logic [8:0] ctrl_q;
   logic       ser_valid = 1'b0, ser_break = 1'b0, ser_ready;
   logic [7:0] ser_data = '0;
   logic       out_valid, out_ready = 1'b0;
   logic [7:0] out_data;
   logic       dr_wr = 1'b0, dr_rd = 1'b0;
   logic [7:0] dr_wdata = '0, dr_rdata;
   logic       overrun;

   int   checks = 0;
   int   fails = 0;
   logic ovr_seen;
   logic [7:0] rv;
   bit   done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_chan_router #(.DATA_W(8), .RX_DEPTH(DEPTH), .TX_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .chan_mode(chan_mode),
      .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
      .ser_valid(ser_valid), .ser_data(ser_data), .ser_break(ser_break), .ser_ready(ser_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
      .dr_wr(dr_wr), .dr_wdata(dr_wdata), .dr_rd(dr_rd), .dr_rdata(dr_rdata),
      .overrun(overrun)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ser_byte(input logic [7:0] d, input logic brk);
      @(negedge clk); ser_valid = 1'b1; ser_data = d; ser_break = brk;
      @(negedge clk); ser_valid = 1'b0; ser_break = 1'b0;
      #1 ovr_seen = overrun;
   endtask

   task automatic dwrite(input logic [7:0] d);
      @(negedge clk); dr_wr = 1'b1; dr_wdata = d;
      @(negedge clk); dr_wr = 1'b0;
      #1 ovr_seen = overrun;
   endtask

   task automatic dread(output logic [7:0] v);
      @(negedge clk); dr_rd = 1'b1;
      #1 v = dr_rdata;
      @(negedge clk); dr_rd = 1'b0;
   endtask

   task automatic txpop();
      @(negedge clk); out_ready = 1'b1;
      @(negedge clk); out_ready = 1'b0;
   endtask

   task automatic cwrite(input logic [8:0] v);
      @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk); ctrl_wr = 1'b0;
      #1;
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk); chan_mode = m;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R8 reset state
      check("R8 ctrl reset", ctrl_q, 9'h128);
      check("R8 tx empty", out_valid, 1'b0);
      check("R10 ready after reset", ser_ready, 1'b1);
      dread(rv);
      check("R6 empty read", rv, 8'h00);

      cwrite(9'h014);
      check("R4 enable write", ctrl_q, 9'h014);

      // routing table, R1 R2 R3
      for (int i = 0; i < 8; i++) begin
         set_mode(VEC[i][12:11]);
         if (VEC[i][10]) dwrite(VEC[i][9:2]);
         else            ser_byte(VEC[i][9:2], 1'b0);
         dread(rv);
         check($sformatf("R1 R3 rx route vec%0d", i), rv, VEC[i][1] ? VEC[i][9:2] : 8'h00);
         #1;
         check($sformatf("R2 R3 tx valid vec%0d", i), out_valid, VEC[i][0]);
         if (VEC[i][0]) begin
            check($sformatf("R2 R11 tx data vec%0d", i), out_data, VEC[i][9:2]);
            txpop();
         end
      end

      // RX fill, overrun, order, ready
      set_mode(2'd0);
      for (int i = 0; i < DEPTH; i++) ser_byte(8'h40 + 8'(i), 1'b0);
      check("R5 no overrun at last fit", ovr_seen, 1'b0);
      check("R10 ready low rx full", ser_ready, 1'b0);
      ser_byte(8'h99, 1'b0);
      check("R5 rx overrun pulse", ovr_seen, 1'b1);
      @(negedge clk); #1;
      check("R5 overrun one cycle", overrun, 1'b0);
      for (int i = 0; i < DEPTH; i++) begin
         dread(rv);
         check("R6 rx order", rv, 8'h40 + 8'(i));
      end
      check("R10 ready after drain", ser_ready, 1'b1);
      dread(rv);
      check("R6 read after drain", rv, 8'h00);

      // TX fill, overrun, ready per mode
      for (int i = 0; i < DEPTH; i++) dwrite(8'h80 + 8'(i));
      check("R10 normal ignores tx full", ser_ready, 1'b1);
      dwrite(8'hEE);
      check("R5 tx overrun pulse", ovr_seen, 1'b1);
      set_mode(2'd1);
      check("R10 echo tx full", ser_ready, 1'b0);
      set_mode(2'd3);
      check("R10 remote tx full", ser_ready, 1'b0);
      set_mode(2'd2);
      check("R10 local always ready", ser_ready, 1'b1);
      check("R11 tx head", out_data, 8'h80);
      txpop();
      #1;
      check("R11 tx next", out_data, 8'h81);
      cwrite(9'h016);
      check("R7 tx flush self clear", ctrl_q, 9'h014);
      check("R7 tx emptied", out_valid, 1'b0);

      // RX flush
      set_mode(2'd0);
      ser_byte(8'h31, 1'b0);
      cwrite(9'h015);
      check("R7 rx flush self clear", ctrl_q, 9'h014);
      dread(rv);
      check("R7 rx emptied", rv, 8'h00);

      // R4 blocked paths
      cwrite(9'h01C);
      ser_byte(8'h77, 1'b0);
      dread(rv);
      check("R4 read blocked", rv, 8'h00);
      cwrite(9'h014);
      dread(rv);
      check("R4 rx push dropped", rv, 8'h00);
      cwrite(9'h034);
      dwrite(8'h66);
      check("R4 tx push dropped", out_valid, 1'b0);
      cwrite(9'h014);

      // R9 break inserts one zero byte
      set_mode(2'd2);
      dwrite(8'h55);
      ser_byte(8'hAA, 1'b1);
      dwrite(8'h56);
      dread(rv);
      check("R9 before break", rv, 8'h55);
      dread(rv);
      check("R9 break zero", rv, 8'h00);
      dread(rv);
      check("R9 after break", rv, 8'h56);
      dread(rv);
      check("R9 single zero only", rv, 8'h00);

      finish_run();
   end
endmodule